// File: doc/BRIEF.md
# Current-Mode Gate Pulse Sequencer

This block decides, one switching cycle at a time, when the power switch gate of a current-mode converter is on. A valley timer upstream asks for each turn-on. The block then holds the gate high until one of three things ends the pulse. The first is the current-sense comparator reporting that the sensed current has reached the level set by the feedback loop. The second is the maximum on-time. The third is an abnormal over-current. The block also produces a slowly rising soft-start reference code for an external DAC. It stops switching while the feedback voltage shows a very light load.

All comparator flags arrive already synchronized to `clk`. The pulse state machine has four states. `ST_IDLE` waits for a request. `ST_BLANK` is the leading-edge blanking interval, in which the normal current comparator is masked. `ST_ON` is the rest of the pulse. `ST_TRIP` is a latched fault.

The transitions are as follows:
- `ST_IDLE` to `ST_BLANK`: a request arrives while no burst hold is active.
- `ST_BLANK` to `ST_ON`: the blanking count ends.
- `ST_BLANK` or `ST_ON` to `ST_IDLE`: the on-time reaches the cap.
- `ST_ON` to `ST_IDLE`: the current-limit flag is seen.
- `ST_BLANK` or `ST_ON` to `ST_TRIP`: the abnormal flag is seen.
- `ST_TRIP`: left only through reset.

A separate hysteresis flop holds off switching during burst operation. A separate prescaled counter produces the soft-start code.

Top module: `pwm_cycle_ctrl`

## Requirements
- R1: While the gate has been high for fewer than LEB_CYC cycles, `cs_over_fb` has no effect. With `cs_over_fb` held high from before the request, the gate stays high for exactly LEB_CYC+1 cycles.
- R2: Once the blanking interval is over, a cycle in which `cs_over_fb` is sampled high is followed by the gate going low on the next cycle (pulse-by-pulse current limit).
- R3: The gate is never high for more than TON_MAX_CYC consecutive cycles. With no current flag, a pulse lasts exactly TON_MAX_CYC cycles.
- R4: `ss_code` is 0 after reset or after a cycle with `restart` high. It then increases by one every SS_STEP_CYC cycles and stays at the all-ones value once it gets there.
- R5: `cs_over_abn` sampled high during any gate-high cycle, blanking included, drives the gate low and `shutdown_req` high on the next cycle. This fault is latched until `rst_n`. Further requests and `restart` leave it in place.
- R6: A cycle with `fb_below_low` high sets the burst hold. A later cycle with `fb_above_high` high and `fb_below_low` low clears it. When both flags are high, the hold is set.
- R7: A turn-on request that arrives while the burst hold is set is dropped. Clearing the hold later starts no pulse unless a new request arrives.
- R8: With `fb_below_low` held high (feedback near 0 V), no request produces any gate pulse.
- R9: A request in idle with no hold and no fault raises the gate on the next cycle.
- R10: After reset, `gate_en` and `shutdown_req` are 0 and `ss_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears the fault latch |
| restart | input | 1 | Restarts the soft-start ramp from zero |
| turn_on_req | input | 1 | One-cycle turn-on request from the valley timer |
| cs_over_fb | input | 1 | Sensed current above the feedback-derived limit |
| cs_over_abn | input | 1 | Sensed current above the abnormal over-current level |
| fb_below_low | input | 1 | Feedback below the burst-low threshold |
| fb_above_high | input | 1 | Feedback above the burst-high threshold |
| gate_en | output | 1 | Gate drive enable |
| ss_code | output | SS_W | Soft-start reference code for the DAC |
| shutdown_req | output | 1 | Latched shutdown request after an abnormal over-current |

## Verification
The bound checker tracks each pulse on every cycle. It checks that the blanking interval masks the current-limit flag, and that the flag ends the pulse once blanking is over. It checks that no pulse outlasts the on-time cap. It checks that an abnormal flag during any high cycle trips a fault that then stays latched with the gate off. It also checks that the soft-start code never decreases except on restart. The burst behaviour needs directed scenarios in the bench. These cover the hysteresis between the two feedback flags, the priority when both are high, requests dropped rather than queued, and zero duty at zero feedback. The exact pulse lengths and ramp step times are also checked in the bench.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ON    = 2'd2,
        ST_TRIP  = 2'd3
    } pcc_state_e;
endpackage

// File: rtl/pcc_softstart.sv
`timescale 1ns/1ps
module pcc_softstart #(
    parameter int SS_W        = 8,
    parameter int SS_STEP_CYC = 6863
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    output logic [SS_W-1:0] code
);
    localparam int PW = $clog2(SS_STEP_CYC + 1);
    localparam logic [PW-1:0]   STEP_LAST = PW'(SS_STEP_CYC - 1);
    localparam logic [SS_W-1:0] FULL      = '1;

    logic [PW-1:0] presc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc <= '0;
            code  <= '0;
        end else if (restart) begin
            presc <= '0;
            code  <= '0;
        end else if (presc == STEP_LAST) begin
            presc <= '0;
            if (code != FULL) code <= code + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end
endmodule

// File: rtl/pcc_burst.sv
`timescale 1ns/1ps
module pcc_burst (
    input  logic clk,
    input  logic rst_n,
    input  logic below_low,
    input  logic above_high,
    output logic hold
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold <= 1'b0;
        else if (below_low)  hold <= 1'b1;
        else if (above_high) hold <= 1'b0;
    end
endmodule

// File: rtl/pcc_pulse_fsm.sv
`timescale 1ns/1ps
module pcc_pulse_fsm
    import pcc_pkg::*;
#(
    parameter int LEB_CYC     = 25,
    parameter int TON_MAX_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic cs_fb,
    input  logic cs_abn,
    output logic gate,
    output logic trip
);
    localparam int TW = $clog2(TON_MAX_CYC + 1);
    localparam logic [TW-1:0] LEB_LAST = TW'(LEB_CYC - 1);
    localparam logic [TW-1:0] TON_LAST = TW'(TON_MAX_CYC - 1);

    pcc_state_e    state_q, state_d;
    logic [TW-1:0] ton_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       ton_cnt <= '0;
        else if (state_q == ST_BLANK || state_q == ST_ON) ton_cnt <= ton_cnt + 1'b1;
        else                                              ton_cnt <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) state_d = ST_BLANK;
            end
            ST_BLANK: begin
                if (cs_abn)                     state_d = ST_TRIP;
                else if (ton_cnt == TON_LAST)   state_d = ST_IDLE;
                else if (ton_cnt == LEB_LAST)   state_d = ST_ON;
            end
            ST_ON: begin
                if (cs_abn)                     state_d = ST_TRIP;
                else if (cs_fb)                 state_d = ST_IDLE;
                else if (ton_cnt == TON_LAST)   state_d = ST_IDLE;
            end
            ST_TRIP: state_d = ST_TRIP;
        endcase
    end

    always_comb begin
        gate = 1'b0;
        trip = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_BLANK: gate = 1'b1;
            ST_ON:    gate = 1'b1;
            ST_TRIP:  trip = 1'b1;
        endcase
    end
endmodule

// File: rtl/pwm_cycle_ctrl.sv
`timescale 1ns/1ps
module pwm_cycle_ctrl #(
    parameter int LEB_CYC     = 25,
    parameter int TON_MAX_CYC = 1000,
    parameter int SS_W        = 8,
    parameter int SS_STEP_CYC = 6863
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            turn_on_req,
    input  logic            cs_over_fb,
    input  logic            cs_over_abn,
    input  logic            fb_below_low,
    input  logic            fb_above_high,
    output logic            gate_en,
    output logic [SS_W-1:0] ss_code,
    output logic            shutdown_req
);
    logic burst_hold;

    pcc_burst u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .below_low  (fb_below_low),
        .above_high (fb_above_high),
        .hold       (burst_hold)
    );

    pcc_pulse_fsm #(
        .LEB_CYC     (LEB_CYC),
        .TON_MAX_CYC (TON_MAX_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (turn_on_req & ~burst_hold),
        .cs_fb    (cs_over_fb),
        .cs_abn   (cs_over_abn),
        .gate     (gate_en),
        .trip     (shutdown_req)
    );

    pcc_softstart #(
        .SS_W        (SS_W),
        .SS_STEP_CYC (SS_STEP_CYC)
    ) u_ss (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .code    (ss_code)
    );
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker #(
    parameter int LEB_CYC     = 25,
    parameter int TON_MAX_CYC = 1000,
    parameter int SS_W        = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            restart,
    input logic            cs_over_fb,
    input logic            cs_over_abn,
    input logic            gate_en,
    input logic [SS_W-1:0] ss_code,
    input logic            shutdown_req
);
    localparam int HW = $clog2(TON_MAX_CYC + 2) + 1;
    localparam logic [HW-1:0] HMAX = '1;

    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             hi_cnt <= '0;
        else if (!gate_en)      hi_cnt <= '0;
        else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
    end

    p_blank_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && hi_cnt < HW'(LEB_CYC) && !cs_over_abn) |=> gate_en);

    p_pulse_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && hi_cnt >= HW'(LEB_CYC) && cs_over_fb) |=> !gate_en);

    p_ton_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> (hi_cnt < HW'(TON_MAX_CYC)));

    p_ss_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (ss_code >= $past(ss_code)));

    p_ss_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ss_code == '0));

    p_abn_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && cs_over_abn) |=> (shutdown_req && !gate_en));

    p_trip_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    p_trip_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> !gate_en);
endmodule

bind pwm_cycle_ctrl pcc_checker #(
    .LEB_CYC     (LEB_CYC),
    .TON_MAX_CYC (TON_MAX_CYC),
    .SS_W        (SS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .cs_over_fb   (cs_over_fb),
    .cs_over_abn  (cs_over_abn),
    .gate_en      (gate_en),
    .ss_code      (ss_code),
    .shutdown_req (shutdown_req)
);

// File: tb/pwm_cycle_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_cycle_ctrl_bench;
    localparam int LEB  = 5;
    localparam int TMAX = 40;
    localparam int SSW  = 4;
    localparam int STEP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0, turn_on_req = 1'b0, cs_over_fb = 1'b0, cs_over_abn = 1'b0;
    logic fb_below_low = 1'b0, fb_above_high = 1'b0;
    logic gate_en, shutdown_req;
    logic [SSW-1:0] ss_code;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_cycle_ctrl #(
        .LEB_CYC (LEB), .TON_MAX_CYC (TMAX), .SS_W (SSW), .SS_STEP_CYC (STEP)
    ) u_pwm_cycle_ctrl (
        .clk (clk), .rst_n (rst_n), .restart (restart), .turn_on_req (turn_on_req),
        .cs_over_fb (cs_over_fb), .cs_over_abn (cs_over_abn),
        .fb_below_low (fb_below_low), .fb_above_high (fb_above_high),
        .gate_en (gate_en), .ss_code (ss_code), .shutdown_req (shutdown_req)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic req_pulse();
        @(negedge clk) turn_on_req = 1'b1;
        @(negedge clk) turn_on_req = 1'b0;
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (gate_en && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        restart = 0; turn_on_req = 0; cs_over_fb = 0; cs_over_abn = 0;
        fb_below_low = 0; fb_above_high = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "gate after reset", int'(gate_en), 0);
        chk("R10", "shutdown after reset", int'(shutdown_req), 0);
        chk("R10", "ss_code after reset", int'(ss_code), 0);
    endtask

    task automatic t_max_on();
        int n;
        req_pulse();
        chk("R9", "gate one cycle after request", int'(gate_en), 1);
        high_len(n);
        chk("R3", "pulse length with no flag", n, TMAX);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_blank();
        int n;
        cs_over_fb = 1'b1;
        req_pulse();
        high_len(n);
        chk("R1", "pulse length with flag held", n, LEB + 1);
        cs_over_fb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_limit();
        int n = 0;
        req_pulse();
        while (gate_en && n < 1000) begin
            n++;
            if (n == 10) cs_over_fb = 1'b1;
            @(negedge clk);
        end
        chk("R2", "pulse length ended by current limit", n, 10);
        cs_over_fb = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_abn();
        int n = 0;
        req_pulse();
        while (gate_en && n < 1000) begin
            n++;
            if (n == 2) cs_over_abn = 1'b1;
            @(negedge clk);
        end
        cs_over_abn = 1'b0;
        chk("R5", "high cycles before abnormal trip", n, 2);
        chk("R5", "shutdown after trip in blanking", int'(shutdown_req), 1);
        req_pulse();
        repeat (2) @(negedge clk);
        chk("R5", "gate after request in fault", int'(gate_en), 0);
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5", "shutdown after restart", int'(shutdown_req), 1);
        t_reset();
        chk("R5", "shutdown cleared by reset", int'(shutdown_req), 0);
    endtask

    task automatic t_softstart();
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
        chk("R4", "ss_code after restart", int'(ss_code), 0);
        repeat (4 * STEP) @(negedge clk);
        chk("R4", "ss_code after four steps", int'(ss_code), 4);
        repeat (20 * STEP) @(negedge clk);
        chk("R4", "ss_code saturated", int'(ss_code), (1 << SSW) - 1);
    endtask

    task automatic t_burst();
        int n;
        int hi = 0;
        fb_below_low = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            req_pulse();
            if (gate_en) hi++;
            @(negedge clk);
            if (gate_en) hi++;
        end
        chk("R8", "gate cycles with feedback held low", hi, 0);
        fb_below_low = 1'b0;
        req_pulse();
        repeat (2) @(negedge clk);
        chk("R6", "gate while hold persists between thresholds", int'(gate_en), 0);
        @(negedge clk) fb_above_high = 1'b1;
        @(negedge clk) fb_above_high = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "gate after hold clears with no new request", int'(gate_en), 0);
        req_pulse();
        chk("R6", "gate after hold cleared", int'(gate_en), 1);
        high_len(n);
        chk("R6", "pulse length after resume", n, TMAX);
        @(negedge clk) begin fb_below_low = 1'b1; fb_above_high = 1'b1; end
        @(negedge clk) begin fb_below_low = 1'b0; fb_above_high = 1'b0; end
        req_pulse();
        chk("R6", "gate when both flags were high", int'(gate_en), 0);
        @(negedge clk) fb_above_high = 1'b1;
        @(negedge clk) fb_above_high = 1'b0;
    endtask

    initial begin
        t_reset();
        t_max_on();
        t_blank();
        t_limit();
        t_softstart();
        t_burst();
        t_abn();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule